// File: doc/BRIEF.md
# Dword-Only Register Access Front End

This block connects a 64-bit host request port to a small bank of 32-bit control, interrupt and statistics registers. Each request carries a quadword address and eight byte enables. The lower four enables select the even dword of the quadword, and the upper four select the odd dword. The block decodes the dword each lane points at and enforces whole-dword access. A write lane takes effect only when all four of its enables are set. A read lane returns the full 32 bits as soon as any of its enables is set.

The interrupt cause register clears on read. Because every read is a whole-dword read, a read that enables only one byte still clears all 32 bits. Each statistics counter counts single-cycle event pulses and holds at its maximum value. Rules for 64-bit accesses keep the odd dword of the quadword untouched and reject 64-bit accesses to the statistics registers entirely. Addresses that no register occupies ignore writes and read as zero.

Register map, by dword index (quadword address times two plus lane):

| Dword | Contents |
|---|---|
| 0 | control, read/write |
| 1 | interrupt mask, read/write |
| 2 | interrupt cause, clears on read |
| 3 | reserved |
| 4 to 7 | statistics counters 0 to 3, read-only |
| all other dwords | reserved |

Top module: `dword_regfront`

## Requirements
- R1: A write lane updates its register only when all four byte enables of that lane are set (lower lane: `req_be[3:0]` equal to 4'hF; upper lane: `req_be[7:4]` equal to 4'hF). A lane with any other non-zero pattern leaves the register unchanged.
- R2: A read lane with at least one byte enable set returns all 32 bits of its dword. The lower lane returns its dword on `rsp_rdata[31:0]` and the upper lane on `rsp_rdata[63:32]`. A lane with no byte enable set returns zero.
- R3: A read that reaches the cause register (dword 2) returns the value the register held before the read and clears all 32 bits, whichever of its byte enables were set.
- R4: A bit of `irq_event` that is high on a clock edge is set in the cause register after that edge and stays set until a clearing read. This holds even when a clearing read is sampled on the same edge.
- R5: The statistics registers (dwords 4 to 7) are read-only and ignore writes. An access to one of them that sets enables in both lanes is rejected as a whole: it reads as zero on both halves and has no effect.
- R6: An access counts as 64-bit when both lanes have at least one enable set. In a 64-bit access the upper (odd) dword is neither written nor read, and `rsp_rdata[63:32]` is zero. The lower dword is handled as in R1 to R3.
- R7: Reserved dwords (dword 3 and all dwords from 8 upward) ignore writes and read as zero.
- R8: Statistics counter i adds one on each clock edge where `stat_evt[i]` is high. It holds at all-ones of its `CNT_W` bits instead of wrapping, and it reads zero-extended to 32 bits.
- R9: `rsp_valid` is high for exactly one cycle, on the cycle after each read request. A write request never raises it.
- R10: After reset the registers hold these values: control is `CTRL_RST` (default 32'h0000_0041), mask is zero, cause is zero and every counter is zero.
- R11: `irq_out` is high whenever any cause bit is set and the matching mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_qaddr | input | QA_W | Quadword address |
| req_be | input | 8 | Byte enables; [3:0] select the even dword, [7:4] the odd dword |
| req_wdata | input | 64 | Write data; [31:0] for the even dword, [63:32] for the odd dword |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data |
| irq_event | input | 32 | Single-cycle interrupt cause pulses |
| stat_evt | input | N_STAT | Single-cycle statistics event pulses |
| irq_out | output | 1 | Interrupt: any cause bit set whose mask bit is also set |

## Verification
The hardest case to reach is a clearing read of the cause register and a new cause event sampled on the same clock edge. Nothing at the ports shows the register's internal state, so the bench gets there in four steps. It first loads one known cause bit. It then drives the read request and a different event bit in the same cycle. It expects the read to return only the old bit. A second read must then return only the new bit. A third case that is hard to hit is rejection of a 64-bit statistics access. The bench builds up known counts with timed event pulses first, so that a 64-bit read of zero can be told apart from a counter that really holds zero.

// File: rtl/regfront_pkg.sv
// Package: regfront_pkg
// Shared types and fixed map constants for the dword register front end.
// Assumes registers are 32 bits wide and each lane selects one dword.
package regfront_pkg;
    localparam int DWORD_W  = 32;
    localparam int LANES    = 2;
    localparam int DW_CTRL  = 0;
    localparam int DW_MASK  = 1;
    localparam int DW_CAUSE = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_MASK,
        SEL_CAUSE,
        SEL_STAT
    } reg_sel_e;
endpackage

// File: rtl/rf_addr_dec.sv
// Module: rf_addr_dec
// Maps one dword index to a register kind and, for statistics, to a counter index.
// Assumes the statistics window does not overlap dwords 0 to 2.
module rf_addr_dec
    import regfront_pkg::*;
#(
    parameter int DI_W      = 5,
    parameter int N_STAT    = 4,
    parameter int STAT_BASE = 4,
    localparam int SI_W     = (N_STAT > 1) ? $clog2(N_STAT) : 1
) (
    input  logic [DI_W-1:0] dw_idx,
    output reg_sel_e        sel,
    output logic [SI_W-1:0] stat_idx
);
    // Classify the dword index against the fixed map and the statistics window.
    always_comb begin
        sel      = SEL_NONE;
        stat_idx = '0;
        if (int'(dw_idx) == DW_CTRL) begin
            sel = SEL_CTRL;
        end else if (int'(dw_idx) == DW_MASK) begin
            sel = SEL_MASK;
        end else if (int'(dw_idx) == DW_CAUSE) begin
            sel = SEL_CAUSE;
        end else if (int'(dw_idx) >= STAT_BASE && int'(dw_idx) < STAT_BASE + N_STAT) begin
            sel      = SEL_STAT;
            stat_idx = SI_W'(int'(dw_idx) - STAT_BASE);
        end
    end
endmodule

// File: rtl/rf_lane.sv
// Module: rf_lane
// Handles one 32-bit lane of a request: write strobes when all four enables are
// set, the cause-clear strobe on a read, and the lane's read data.
// Assumes act is already gated by the 64-bit access rules in the top module.
module rf_lane
    import regfront_pkg::*;
#(
    parameter int DI_W      = 5,
    parameter int N_STAT    = 4,
    parameter int STAT_BASE = 4
) (
    input  logic                            act,
    input  logic                            write,
    input  logic [DI_W-1:0]                 dw_idx,
    input  logic [3:0]                      be,
    input  logic [DWORD_W-1:0]              ctrl_val,
    input  logic [DWORD_W-1:0]              mask_val,
    input  logic [DWORD_W-1:0]              cause_val,
    input  logic [N_STAT-1:0][DWORD_W-1:0]  stat_val,
    output logic                            is_stat,
    output logic                            wr_ctrl,
    output logic                            wr_mask,
    output logic                            clr_cause,
    output logic [DWORD_W-1:0]              rdata
);
    localparam int SI_W = (N_STAT > 1) ? $clog2(N_STAT) : 1;

    reg_sel_e        sel;
    logic [SI_W-1:0] sidx;
    logic            full_wr;
    logic            any_rd;

    rf_addr_dec #(
        .DI_W      (DI_W),
        .N_STAT    (N_STAT),
        .STAT_BASE (STAT_BASE)
    ) u_dec (
        .dw_idx   (dw_idx),
        .sel      (sel),
        .stat_idx (sidx)
    );

    // Qualify the lane: whole-dword write or any-byte read.
    always_comb begin
        full_wr = act && write && (be == 4'hF);
        any_rd  = act && !write && (be != 4'h0);
    end

    // Produce the write and clear strobes and the full-dword read data.
    always_comb begin
        is_stat   = (sel == SEL_STAT);
        wr_ctrl   = full_wr && (sel == SEL_CTRL);
        wr_mask   = full_wr && (sel == SEL_MASK);
        clr_cause = any_rd && (sel == SEL_CAUSE);
        rdata     = '0;
        if (any_rd) begin
            case (sel)
                SEL_CTRL:  rdata = ctrl_val;
                SEL_MASK:  rdata = mask_val;
                SEL_CAUSE: rdata = cause_val;
                SEL_STAT:  rdata = stat_val[sidx];
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rf_sat_counter.sv
// Module: rf_sat_counter
// Event counter that adds one per pulse and holds at all-ones.
// Assumes at most one event per clock.
module rf_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count pulses and stop at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != {CNT_W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rf_cause_reg.sv
// Module: rf_cause_reg
// Sticky interrupt cause bits with clear-on-read; new events win over a clear.
// Assumes clear is a single-cycle strobe from a read.
module rf_cause_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic         clear,
    output logic [W-1:0] value
);
    // Clear everything on a read, then merge the events of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            value <= (clear ? '0 : value) | set_bits;
        end
    end
endmodule

// File: rtl/dword_regfront.sv
// Module: dword_regfront
// Front end between a 64-bit request port and 32-bit registers. Each access is
// forced to whole dwords, the 64-bit access rules are applied, and one read
// response is returned a cycle after each read request.
// Assumes one request per cycle at most, with no back-pressure.
module dword_regfront
    import regfront_pkg::*;
#(
    parameter int          QA_W      = 4,
    parameter int          N_STAT    = 4,
    parameter int          STAT_BASE = 4,
    parameter int          CNT_W     = 32,
    parameter logic [31:0] CTRL_RST  = 32'h0000_0041
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [QA_W-1:0]   req_qaddr,
    input  logic [7:0]        req_be,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    input  logic [31:0]       irq_event,
    input  logic [N_STAT-1:0] stat_evt,
    output logic              irq_out
);
    localparam int DI_W = QA_W + 1;

    logic [DWORD_W-1:0]              ctrl_q;
    logic [DWORD_W-1:0]              mask_q;
    logic [DWORD_W-1:0]              cause_q;
    logic [N_STAT-1:0][CNT_W-1:0]    stat_cnt;
    logic [N_STAT-1:0][DWORD_W-1:0]  stat_val;

    logic                   lo_any, hi_any, is64, reject64;
    logic [LANES-1:0]       lane_act;
    logic [LANES-1:0]       lane_stat, lane_wr_ctrl, lane_wr_mask, lane_clr;
    logic [DWORD_W-1:0]     lane_rdata [LANES];
    logic                   clr_cause;

    // Classify the request: which lanes are enabled and whether it is 64-bit.
    always_comb begin
        lo_any   = |req_be[3:0];
        hi_any   = |req_be[7:4];
        is64     = lo_any && hi_any;
        reject64 = is64 && (lane_stat[0] || lane_stat[1]);
        lane_act[0] = req_valid && lo_any && !reject64;
        lane_act[1] = req_valid && hi_any && !is64;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rf_lane #(
            .DI_W      (DI_W),
            .N_STAT    (N_STAT),
            .STAT_BASE (STAT_BASE)
        ) u_lane (
            .act       (lane_act[l]),
            .write     (req_write),
            .dw_idx    ({req_qaddr, 1'(l)}),
            .be        (req_be[4*l +: 4]),
            .ctrl_val  (ctrl_q),
            .mask_val  (mask_q),
            .cause_val (cause_q),
            .stat_val  (stat_val),
            .is_stat   (lane_stat[l]),
            .wr_ctrl   (lane_wr_ctrl[l]),
            .wr_mask   (lane_wr_mask[l]),
            .clr_cause (lane_clr[l]),
            .rdata     (lane_rdata[l])
        );
    end

    for (genvar s = 0; s < N_STAT; s++) begin : g_stat
        rf_sat_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (stat_evt[s]),
            .count (stat_cnt[s])
        );
        assign stat_val[s] = DWORD_W'(stat_cnt[s]);
    end

    assign clr_cause = |lane_clr;

    rf_cause_reg #(
        .W (DWORD_W)
    ) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (irq_event),
        .clear    (clr_cause),
        .value    (cause_q)
    );

    // Update the control register from whichever lane wrote it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (lane_wr_ctrl[0]) begin
            ctrl_q <= req_wdata[31:0];
        end else if (lane_wr_ctrl[1]) begin
            ctrl_q <= req_wdata[63:32];
        end
    end

    // Update the mask register from whichever lane wrote it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (lane_wr_mask[0]) begin
            mask_q <= req_wdata[31:0];
        end else if (lane_wr_mask[1]) begin
            mask_q <= req_wdata[63:32];
        end
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_rdata <= {lane_rdata[1], lane_rdata[0]};
            end
        end
    end

    assign irq_out = |(cause_q & mask_q);
endmodule

// File: rtl/dword_regfront_chk.sv
// Module: dword_regfront_chk
// Property checker bound into dword_regfront.
// Assumes the default register map.
module dword_regfront_chk #(
    parameter int QA_W      = 4,
    parameter int N_STAT    = 4,
    parameter int STAT_BASE = 4,
    parameter int CNT_W     = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_write,
    input logic [QA_W-1:0]              req_qaddr,
    input logic [7:0]                   req_be,
    input logic [31:0]                  irq_event,
    input logic                         rsp_valid,
    input logic [63:0]                  rsp_rdata,
    input logic [31:0]                  ctrl_q,
    input logic [31:0]                  cause_q,
    input logic [N_STAT-1:0][CNT_W-1:0] stat_cnt
);
    logic rd_req, both_lanes, stat_qw;
    assign rd_req     = req_valid && !req_write;
    assign both_lanes = (|req_be[3:0]) && (|req_be[7:4]);
    assign stat_qw    = (int'(req_qaddr) * 2 >= STAT_BASE) &&
                        (int'(req_qaddr) * 2 < STAT_BASE + N_STAT);

    a_r1_partial_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_qaddr == '0 && req_be[3:0] != 4'hF) |=> $stable(ctrl_q));

    a_r3_read_clears_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && int'(req_qaddr) == 1 && (|req_be[3:0])) |=> (cause_q == $past(irq_event)));

    a_r5_stat_wide_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && both_lanes && stat_qw) |=> (rsp_rdata == 64'h0));

    a_r6_upper_dword_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && both_lanes) |=> (rsp_rdata[63:32] == 32'h0));

    a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

    a_r9_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

    for (genvar i = 0; i < N_STAT; i++) begin : g_chk
        a_r8_never_decreases: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (stat_cnt[i] >= $past(stat_cnt[i])));
        a_r8_holds_at_max: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_cnt[i] == {CNT_W{1'b1}}) |=> (stat_cnt[i] == {CNT_W{1'b1}}));
    end
endmodule

bind dword_regfront dword_regfront_chk #(
    .QA_W      (QA_W),
    .N_STAT    (N_STAT),
    .STAT_BASE (STAT_BASE),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_qaddr (req_qaddr),
    .req_be    (req_be),
    .irq_event (irq_event),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ctrl_q    (ctrl_q),
    .cause_q   (cause_q),
    .stat_cnt  (stat_cnt)
);

// File: tb/sim_dword_regfront.sv
`timescale 1ns/1ps
// Bench: scoreboard for dword_regfront. Read tasks queue the expected data;
// a monitor pops one entry per response and compares it.
module sim_dword_regfront;
    localparam int QA_W = 4;
    localparam int NS   = 4;
    localparam int CW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [QA_W-1:0] req_qaddr = '0;
    logic [7:0]      req_be = '0;
    logic [63:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [63:0]     rsp_rdata;
    logic [31:0]     irq_event = '0;
    logic [NS-1:0]   stat_evt = '0;
    logic            irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    dword_regfront #(.QA_W(QA_W), .N_STAT(NS), .STAT_BASE(4), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_qaddr(req_qaddr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_event(irq_event),
        .stat_evt(stat_evt), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every read response against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R9 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [QA_W-1:0] qa, input logic [7:0] be, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_qaddr = qa; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 write gives no response", 64'(rsp_valid), 64'h0);
    endtask

    task automatic bus_read(input logic [QA_W-1:0] qa, input logic [7:0] be,
                            input logic [63:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_qaddr = qa; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_irq(input logic [31:0] bits);
        @(negedge clk);
        irq_event = bits;
        @(negedge clk);
        irq_event = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset values
        bus_read(0, 8'h0F, 64'h0000_0000_0000_0041, "R10 control reset");
        bus_read(0, 8'hF0, 64'h0, "R10 mask reset");
        bus_read(1, 8'h0F, 64'h0, "R10 cause reset");
        @(negedge clk);
        check("R11 irq low after reset", 64'(irq_out), 64'h0);

        // R1: partial writes ignored; full write accepted
        bus_write(0, 8'h07, 64'hDEAD_BEEF);
        bus_read(0, 8'h0F, 64'h41, "R1 partial write ignored");
        bus_write(0, 8'h0F, 64'h1234_5678);
        bus_read(0, 8'h0F, 64'h1234_5678, "R1 full write applied");
        // R2: partial read returns whole dword
        bus_read(0, 8'h01, 64'h1234_5678, "R2 one-byte read full dword");
        bus_write(0, 8'hF0, 64'h0000_00FF_0000_0000);
        bus_read(0, 8'h40, 64'h0000_00FF_0000_0000, "R2 upper lane mask read");
        bus_write(0, 8'h70, 64'hFFFF_FFFF_0000_0000);
        bus_read(0, 8'hF0, 64'h0000_00FF_0000_0000, "R1 partial upper write ignored");

        // R6: 64-bit write touches only the lower dword; 64-bit read hides upper
        bus_write(0, 8'hFF, 64'hAAAA_AAAA_5555_5555);
        bus_read(0, 8'h0F, 64'h5555_5555, "R6 lower dword written");
        bus_read(0, 8'hF0, 64'h0000_00FF_0000_0000, "R6 upper dword untouched");
        bus_read(0, 8'hFF, 64'h5555_5555, "R6 wide read upper zero");

        // R3 and R11: cause set, one-byte read clears all bits
        pulse_irq(32'h0000_0011);
        check("R11 irq raised", 64'(irq_out), 64'h1);
        bus_read(1, 8'h02, 64'h11, "R3 read returns cause");
        bus_read(1, 8'h0F, 64'h0, "R3 cause fully cleared");
        check("R11 irq dropped", 64'(irq_out), 64'h0);
        pulse_irq(32'h0001_0000);
        check("R11 masked cause no irq", 64'(irq_out), 64'h0);
        bus_read(1, 8'h08, 64'h0001_0000, "R4 sticky cause");

        // R4: event in the same cycle as a clearing read survives it
        pulse_irq(32'h0000_0004);
        exp_q.push_back(64'h4);
        tag_q.push_back("R4 read sees old cause");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_qaddr = 1; req_be = 8'h0F;
        irq_event = 32'h0000_0100;
        @(negedge clk);
        req_valid = 1'b0; irq_event = '0;
        bus_read(1, 8'h0F, 64'h100, "R4 same-cycle event kept");
        bus_read(1, 8'h0F, 64'h0, "R4 cleared afterwards");

        // R8: counting and saturation
        @(negedge clk);
        stat_evt = 4'b0001;
        repeat (3) @(negedge clk);
        stat_evt = 4'b0010;
        repeat (300) @(negedge clk);
        stat_evt = 4'b0100;
        @(negedge clk);
        stat_evt = 4'b0000;
        bus_read(2, 8'h0F, 64'h3, "R8 counter 0 counts three");
        bus_read(2, 8'hF0, 64'h0000_00FF_0000_0000, "R8 counter 1 saturated");
        bus_read(3, 8'h01, 64'h1, "R8 counter 2 counts one");

        // R5: stats read-only; wide access rejected
        bus_write(2, 8'h0F, 64'h0);
        bus_read(2, 8'h0F, 64'h3, "R5 write to counter ignored");
        bus_read(2, 8'hFF, 64'h0, "R5 wide counter read zero");
        bus_read(3, 8'h11, 64'h0, "R5 wide partial counter read zero");
        bus_read(1, 8'hFF, 64'h0, "R7 cause empty under wide read");

        // R7: reserved dwords
        bus_write(5, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(5, 8'hFF, 64'h0, "R7 reserved quadword reads zero");
        bus_write(1, 8'hF0, 64'hFFFF_FFFF_0000_0000);
        bus_read(1, 8'hF0, 64'h0, "R7 dword 3 reads zero");
        bus_read(0, 8'h00, 64'h0, "R2 no enables reads zero");

        repeat (3) @(negedge clk);
        check("R9 all responses seen", 64'(exp_q.size()), 64'h0);
        finish_run();
    end
endmodule